// File: doc/BRIEF.md
# Truncatable Signed Serial Multiplier

This block multiplies two 16-bit two's complement operands by shift-and-add and handles one multiplier bit per clock. The multiplier is loaded into the low half of a double-width partial product. On each step the lowest remaining multiplier bit decides between two actions. The first is to add the multiplicand into the upper half and then shift right arithmetically. The second is to shift only. On the step that handles the multiplier's sign bit, the multiplicand is subtracted rather than added. That subtraction gives the correct signed result without recoding.

A truncation count trades precision for switching activity. The given number of low-order multiplier bits are treated as zero whatever their values, so those steps only shift. A count of zero gives the exact product. A count of sixteen or more gives zero. A one-cycle start pulse begins a run, and the operands and count are taken on that edge. A one-cycle done pulse marks the new product, which is held until the next done.

Top module: `trunc_serial_mult`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, product is 0 and busy and done are low.
- R2: A start seen while busy is low begins a run, and busy is high in the cycle that follows.
- R3: done is high for exactly one cycle. It rises after the 16th rising edge, counting the edge that accepted start as the first, and busy is low in that same cycle.
- R4: With a truncation count of 0, product equals the exact signed 32-bit product of the two 16-bit two's complement operands, including operands of -32768.
- R5: With a truncation count t from 1 to 15, product equals the multiplicand times the multiplier with its t lowest bits (bit positions 0 to t-1) cleared. The multiplier's sign bit is kept.
- R6: With a truncation count from 16 to 31 (5-bit field), product is 0.
- R7: While busy is high, start pulses have no effect, and neither do changes on the operand and truncation inputs: the running result is unchanged and no extra done is produced.
- R8: product changes only in a cycle in which done is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a run, honoured only when idle |
| mcand_a | input | 16 | Signed multiplicand |
| mplier_b | input | 16 | Signed multiplier |
| trunc_cnt | input | 5 | Number of low multiplier bits forced to zero |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when product is updated |
| product | output | 32 | Signed product of the last completed run |

## Verification
The checker assumes that operands and truncation count are valid on the edge where start is accepted. It also assumes that start may arrive at any time, including while busy is high, and that it must then be ignored. The stimulus asserts start only at falling edges. During runs it deliberately drives junk operands, a different count and extra start pulses, so that the sampling rule in R7 is exercised and never merely assumed. The operand values include both extremes of the signed range and truncation counts at 0, 15, 16 and above 16.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } tsm_phase_e;

endpackage

// File: rtl/tsm_bit_sel.sv
module tsm_bit_sel #(
    parameter int CNT_W = 4,
    parameter int TRN_W = 5
) (
    input  logic             raw_bit,
    input  logic [CNT_W-1:0] step_idx,
    input  logic [TRN_W-1:0] trunc,
    output logic             bit_on
);
    // A step below the truncation count sees a zero bit.
    always_comb begin
        bit_on = raw_bit && (TRN_W'(step_idx) >= trunc);
    end
endmodule

// File: rtl/tsm_step.sv
module tsm_step #(
    parameter int OP_W = 16
) (
    input  logic [OP_W-1:0] hi_in,
    input  logic [OP_W-1:0] lo_in,
    input  logic [OP_W-1:0] mcand,
    input  logic            bit_on,
    input  logic            last,
    output logic [OP_W-1:0] hi_out,
    output logic [OP_W-1:0] lo_out
);
    localparam int EXT_W = OP_W + 1;

    logic [EXT_W-1:0] hi_ext;
    logic [EXT_W-1:0] mc_ext;
    logic [EXT_W-1:0] addend;
    logic [EXT_W-1:0] pre_shift;

    always_comb begin
        hi_ext    = {hi_in[OP_W-1], hi_in};
        mc_ext    = {mcand[OP_W-1], mcand};
        // sign step subtracts the multiplicand
        addend    = last ? (~mc_ext + EXT_W'(1)) : mc_ext;
        pre_shift = bit_on ? (hi_ext + addend) : hi_ext;
        hi_out    = pre_shift[EXT_W-1:1];
        lo_out    = {pre_shift[0], lo_in[OP_W-1:1]};
    end
endmodule

// File: rtl/trunc_serial_mult.sv
module trunc_serial_mult
    import tsm_pkg::*;
#(
    parameter int  OP_W  = 16,
    localparam int CNT_W = $clog2(OP_W),
    localparam int TRN_W = $clog2(OP_W + 1),
    localparam int PR_W  = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OP_W-1:0]  mcand_a,
    input  logic [OP_W-1:0]  mplier_b,
    input  logic [TRN_W-1:0] trunc_cnt,
    output logic             busy,
    output logic             done,
    output logic [PR_W-1:0]  product
);

    typedef struct packed {
        tsm_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic [TRN_W-1:0] trn;
        logic [OP_W-1:0]  mcand;
        logic [OP_W-1:0]  hi;
        logic [OP_W-1:0]  lo;
        logic [PR_W-1:0]  prod;
        logic             done;
    } tsm_state_t;

    tsm_state_t st_q, st_d;

    logic             running;
    logic [OP_W-1:0]  src_hi, src_lo, src_mc;
    logic [TRN_W-1:0] src_trn;
    logic [CNT_W-1:0] src_idx;
    logic             eff_bit, last_step;
    logic [OP_W-1:0]  hi_nx, lo_nx;

    // Step 0 runs on the accepting edge from the raw inputs.
    always_comb begin
        running   = (st_q.phase == PH_RUN);
        src_hi    = running ? st_q.hi    : '0;
        src_lo    = running ? st_q.lo    : mplier_b;
        src_mc    = running ? st_q.mcand : mcand_a;
        src_trn   = running ? st_q.trn   : trunc_cnt;
        src_idx   = running ? st_q.cnt   : '0;
        last_step = (src_idx == CNT_W'(OP_W - 1));
    end

    tsm_bit_sel #(
        .CNT_W (CNT_W),
        .TRN_W (TRN_W)
    ) u_bit_sel (
        .raw_bit  (src_lo[0]),
        .step_idx (src_idx),
        .trunc    (src_trn),
        .bit_on   (eff_bit)
    );

    tsm_step #(
        .OP_W (OP_W)
    ) u_step (
        .hi_in  (src_hi),
        .lo_in  (src_lo),
        .mcand  (src_mc),
        .bit_on (eff_bit),
        .last   (last_step),
        .hi_out (hi_nx),
        .lo_out (lo_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (running) begin
            st_d.hi  = hi_nx;
            st_d.lo  = lo_nx;
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (last_step) begin
                st_d.phase = PH_IDLE;
                st_d.prod  = {hi_nx, lo_nx};
                st_d.done  = 1'b1;
            end
        end else if (start) begin
            st_d.phase = PH_RUN;
            st_d.hi    = hi_nx;
            st_d.lo    = lo_nx;
            st_d.mcand = mcand_a;
            st_d.trn   = trunc_cnt;
            st_d.cnt   = CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.phase == PH_RUN);
    assign done    = st_q.done;
    assign product = st_q.prod;

endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
    parameter int  OP_W  = 16,
    localparam int TRN_W = $clog2(OP_W + 1),
    localparam int LEN_W = $clog2(OP_W + 1),
    localparam int PR_W  = 2 * OP_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OP_W-1:0]  mcand_a,
    input logic [OP_W-1:0]  mplier_b,
    input logic [TRN_W-1:0] trunc_cnt,
    input logic             busy,
    input logic             done,
    input logic [PR_W-1:0]  product
);
    logic signed [OP_W-1:0] cap_a, cap_b, cut_b;
    logic [TRN_W-1:0]       cap_t;
    logic [LEN_W-1:0]       run_len;
    logic signed [PR_W-1:0] model;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            cap_t   <= '0;
            run_len <= '0;
        end else begin
            if (start && !busy) begin
                cap_a <= mcand_a;
                cap_b <= mplier_b;
                cap_t <= trunc_cnt;
            end
            run_len <= busy ? run_len + LEN_W'(1) : '0;
        end
    end

    always_comb begin
        for (int i = 0; i < OP_W; i++) begin
            cut_b[i] = cap_b[i] && (i >= int'(cap_t));
        end
        model = cap_a * cut_b;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1 : assert (!done && !busy && product == '0);
        end
    end

    assert_start_busy_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_pulse_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_run_length_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == LEN_W'(OP_W - 1) && !busy));

    assert_busy_end_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_exact_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_t == '0) |-> ($signed(product) == cap_a * cap_b));

    assert_truncated_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($signed(product) == model));

    assert_zero_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (done && int'(cap_t) >= OP_W) |-> (product == '0));

    assert_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));

endmodule

bind trunc_serial_mult tsm_checker #(.OP_W(OP_W)) u_tsm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mcand_a   (mcand_a),
    .mplier_b  (mplier_b),
    .trunc_cnt (trunc_cnt),
    .busy      (busy),
    .done      (done),
    .product   (product)
);

// File: tb/trunc_serial_mult_bench.sv
`timescale 1ns/1ps
module trunc_serial_mult_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mcand_a = '0;
    logic [15:0] mplier_b = '0;
    logic [4:0]  trunc_cnt = '0;
    logic        busy, done;
    logic [31:0] product;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] exp_q[$];
    logic [31:0] last_prod;

    always #10 clk = ~clk;

    trunc_serial_mult u_trunc_serial_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mcand_a   (mcand_a),
        .mplier_b  (mplier_b),
        .trunc_cnt (trunc_cnt),
        .busy      (busy),
        .done      (done),
        .product   (product)
    );

    function automatic logic [31:0] expect_prod(logic [15:0] a, logic [15:0] b, int t);
        logic signed [15:0] kb;
        logic signed [31:0] r;
        for (int i = 0; i < 16; i++) kb[i] = (i >= t) ? b[i] : 1'b0;
        r = $signed(a) * kb;
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare every done against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected done", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check("R4/R5/R6 product", product, e);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_op(logic [15:0] a, logic [15:0] b, logic [4:0] t, bit disturb);
        int k;
        exp_q.push_back(expect_prod(a, b, int'(t)));
        mcand_a = a; mplier_b = b; trunc_cnt = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R7: junk on the inputs after acceptance
        mcand_a = ~a; mplier_b = b ^ 16'h5a5a; trunc_cnt = 5'd16;
        k = 1;
        check("R2 busy after start", 32'(busy), 32'd1);
        while (!done && k < 40) begin
            if (disturb && k == 5) start = 1'b1;
            if (disturb && k == 6) start = 1'b0;
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check("R3 latency", 32'(k), 32'd16);
        check("R3 busy low at done", 32'(busy), 32'd0);
        last_prod = product;
        @(negedge clk);
        check("R3 done one cycle", 32'(done), 32'd0);
        @(negedge clk);
        check("R8 product held", product, last_prod);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset product", product, 32'd0);
        check("R1 reset busy", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", {30'd0, busy, done}, 32'd0);

        run_op(16'd3, 16'd5, 5'd0, 1'b0);                 // R4
        run_op(16'hfffd, 16'd7, 5'd0, 1'b0);              // R4
        run_op(16'd1234, 16'hff00, 5'd0, 1'b0);           // R4
        run_op(16'h8000, 16'h8000, 5'd0, 1'b0);           // R4
        run_op(16'h8000, 16'h7fff, 5'd0, 1'b0);           // R4
        run_op(16'hffff, 16'hffff, 5'd0, 1'b0);           // R4
        run_op(16'h7fff, 16'h7fff, 5'd0, 1'b0);           // R4
        run_op(16'd0, 16'h8000, 5'd0, 1'b0);              // R4
        run_op(16'd321, 16'h00ff, 5'd4, 1'b0);            // R5
        run_op(16'hf00d, 16'hbeef, 5'd8, 1'b0);           // R5
        run_op(16'h1357, 16'hffff, 5'd15, 1'b0);          // R5
        run_op(16'h2468, 16'h7fff, 5'd15, 1'b0);          // R5
        run_op(16'h7abc, 16'h9999, 5'd16, 1'b0);          // R6
        run_op(16'h8000, 16'hffff, 5'd31, 1'b0);          // R6
        run_op(16'd77, 16'hfff3, 5'd1, 1'b1);             // R7 start while busy
        run_op(16'h8001, 16'h4321, 5'd0, 1'b1);           // R7
        repeat (20) @(negedge clk);
        check("R7 no extra result", 32'(exp_q.size()), 32'd0);
        check("R8 product held idle", product, last_prod);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule